// File: doc/BRIEF.md
# System Interrupt Pending and Mask Unit

This block collects interrupt requests into two independent groups and raises one interrupt line per group. The system group holds a pending register and a mask register. Hardware sources set and clear single pending bits by giving a bit index, and a periodic timer acknowledges its own request by writing a status register. The communications group holds a pending register that software clears by writing ones, a mask register, and a configuration word that the block stores for software but does not interpret.

Software reaches every register through a simple single-cycle register bus. Writes take effect at the clock edge. Reads return the addressed register combinationally in the same cycle. Each interrupt output is the OR-reduction of its group's pending bits ANDed with that group's mask. Because the output is computed from registered state, it follows a write at the next clock edge.

Register selection uses the word address `bus_addr_i`: 0 is the system pending register (read-only), 1 is the system mask, 2 is the timer status register (write-only, reads as zero), 3 is the communications pending register (write-one-to-clear), 4 is the communications mask, and 5 is the communications configuration. Every other address, including any address with a bit set above bit 2, is unmapped.

Top module: `sys_irq_ctrl`

## Requirements
- R1: After reset every register reads as zero, and both `sys_irq_o` and `cm_irq_o` are low.
- R2: A cycle with `set_vld_i` high and `set_idx_i` = n sets bit n of the system pending register at the next clock edge.
- R3: A cycle with `clr_vld_i` high and `clr_idx_i` = n clears bit n of the system pending register at the next clock edge. Other bits are unaffected.
- R4: When a set and a clear name the same bit in the same cycle, that bit ends up set.
- R5: Bus writes to address 0 (system pending) are ignored, and the register keeps its value.
- R6: The system mask (address 1) stores the written value and reads it back. `sys_irq_o` is high exactly when some bit is set in both the system pending and the system mask registers.
- R7: A write to address 2 with data bit 7 set clears system pending bit 30. A write to that address with bit 7 clear changes nothing, and no other pending bit is touched. If the same cycle also has an index set of bit 30, the bit stays set.
- R8: A write to address 3 clears every communications pending bit that is 1 in the written data and keeps every bit that is 0.
- R9: Each bit of `cm_src_i` that is high in a cycle sets the matching communications pending bit at the next edge. This set wins over a same-cycle write-one-to-clear of that bit.
- R10: The communications mask (address 4) stores the written value and reads it back. `cm_irq_o` is high exactly when some bit is set in both the communications pending and mask registers.
- R11: The configuration register (address 5) is plain read/write and has no effect on either interrupt output.
- R12: Reads of address 2 and of unmapped addresses return zero. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_vld_i | input | 1 | Indexed set request for the system pending register |
| set_idx_i | input | 5 | Bit index to set |
| clr_vld_i | input | 1 | Indexed clear request for the system pending register |
| clr_idx_i | input | 5 | Bit index to clear |
| cm_src_i | input | 32 | Per-bit set requests for the communications pending register |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| sys_irq_o | output | 1 | System group interrupt |
| cm_irq_o | output | 1 | Communications group interrupt |

## Verification
The bound checker watches the following on every cycle:
- an indexed set lands one edge later, and an uncontested clear takes its bit away;
- a bus write to the system pending register leaves it stable;
- a timer acknowledge removes bit 30 unless a same-cycle set of bit 30 wins;
- written ones vanish from the communications pending register, except where a source raises that bit;
- source bits always appear in that register;
- an interrupt line is never high without both pending and mask bits present.

Only the directed scenarios show the following:
- reset values;
- read-back of the mask and configuration words;
- that a timer write without bit 7, or a write to an unmapped address, changes nothing;
- that the configuration word leaves both interrupt lines unchanged;
- that an interrupt actually rises once a pending bit and its mask bit meet.

// File: rtl/sys_irq_pkg.sv
package sys_irq_pkg;

    localparam int unsigned SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        REG_SYS_PEND = 3'd0,
        REG_SYS_MASK = 3'd1,
        REG_TMR_STAT = 3'd2,
        REG_CM_PEND  = 3'd3,
        REG_CM_MASK  = 3'd4,
        REG_CM_CFG   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic sys_mask_we;
        logic tmr_clr;
        logic cm_w1c;
        logic cm_mask_we;
        logic cm_cfg_we;
    } wr_strb_t;

endpackage

// File: rtl/sys_irq_bus.sv
module sys_irq_bus
    import sys_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              tmr_ack_i,
    input  logic [DATA_W-1:0] sys_pend_i,
    input  logic [DATA_W-1:0] sys_mask_i,
    input  logic [DATA_W-1:0] cm_pend_i,
    input  logic [DATA_W-1:0] cm_mask_i,
    input  logic [DATA_W-1:0] cm_cfg_i,
    output wr_strb_t          strb_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic           addr_hit;
    logic [SEL_W-1:0] sel;

    assign sel = bus_addr_i[SEL_W-1:0];

    generate
        if (ADDR_W > SEL_W) begin : g_hi_dec
            assign addr_hit = (bus_addr_i[ADDR_W-1:SEL_W] == '0);
        end else begin : g_no_hi
            assign addr_hit = 1'b1;
        end
    endgenerate

    always_comb begin
        strb_o = '0;
        if (bus_we_i && addr_hit) begin
            unique case (sel)
                REG_SYS_MASK: strb_o.sys_mask_we = 1'b1;
                REG_TMR_STAT: strb_o.tmr_clr     = tmr_ack_i;
                REG_CM_PEND:  strb_o.cm_w1c      = 1'b1;
                REG_CM_MASK:  strb_o.cm_mask_we  = 1'b1;
                REG_CM_CFG:   strb_o.cm_cfg_we   = 1'b1;
                default:      strb_o             = '0;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_hit) begin
            unique case (sel)
                REG_SYS_PEND: rdata_o = sys_pend_i;
                REG_SYS_MASK: rdata_o = sys_mask_i;
                REG_CM_PEND:  rdata_o = cm_pend_i;
                REG_CM_MASK:  rdata_o = cm_mask_i;
                REG_CM_CFG:   rdata_o = cm_cfg_i;
                default:      rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/sys_irq_grp_idx.sv
module sys_irq_grp_idx #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned TMR_BIT = 30,
    localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              set_vld_i,
    input  logic [IDX_W-1:0]  set_idx_i,
    input  logic              clr_vld_i,
    input  logic [IDX_W-1:0]  clr_idx_i,
    input  logic              tmr_clr_i,
    input  logic              mask_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] pend_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] mask;
    } grp_state_t;

    grp_state_t        st_d, st_q;
    logic [DATA_W-1:0] set_vec_d, clr_vec_d;

    always_comb begin
        set_vec_d = set_vld_i ? (DATA_W'(1) << set_idx_i) : '0;
        clr_vec_d = clr_vld_i ? (DATA_W'(1) << clr_idx_i) : '0;
        if (tmr_clr_i) begin
            clr_vec_d[TMR_BIT] = 1'b1;
        end
        st_d      = st_q;
        // clears first, then sets, so a set always wins
        st_d.pend = (st_q.pend & ~clr_vec_d) | set_vec_d;
        if (mask_we_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.pend & st_q.mask);

endmodule

// File: rtl/sys_irq_grp_w1c.sv
module sys_irq_grp_w1c #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] src_i,
    input  logic              w1c_i,
    input  logic              mask_we_i,
    input  logic              cfg_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] pend_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] cfg_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] cfg;
    } grp_state_t;

    grp_state_t        st_d, st_q;
    logic [DATA_W-1:0] clr_vec_d;

    always_comb begin
        clr_vec_d = w1c_i ? wdata_i : '0;
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_vec_d) | src_i;
        if (mask_we_i) begin
            st_d.mask = wdata_i;
        end
        if (cfg_we_i) begin
            st_d.cfg = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign cfg_o  = st_q.cfg;
    assign irq_o  = |(st_q.pend & st_q.mask);

endmodule

// File: rtl/sys_irq_ctrl.sv
module sys_irq_ctrl
    import sys_irq_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned TMR_BIT     = 30,
    parameter int unsigned TMR_ACK_BIT = 7,
    localparam int unsigned IDX_W      = $clog2(DATA_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              set_vld_i,
    input  logic [IDX_W-1:0]  set_idx_i,
    input  logic              clr_vld_i,
    input  logic [IDX_W-1:0]  clr_idx_i,
    input  logic [DATA_W-1:0] cm_src_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              sys_irq_o,
    output logic              cm_irq_o
);

    wr_strb_t          strb;
    logic [DATA_W-1:0] sys_pend_q, sys_mask_q;
    logic [DATA_W-1:0] cm_pend_q, cm_mask_q, cm_cfg_q;

    sys_irq_bus #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .bus_we_i   (bus_we_i),
        .bus_addr_i (bus_addr_i),
        .tmr_ack_i  (bus_wdata_i[TMR_ACK_BIT]),
        .sys_pend_i (sys_pend_q),
        .sys_mask_i (sys_mask_q),
        .cm_pend_i  (cm_pend_q),
        .cm_mask_i  (cm_mask_q),
        .cm_cfg_i   (cm_cfg_q),
        .strb_o     (strb),
        .rdata_o    (bus_rdata_o)
    );

    sys_irq_grp_idx #(
        .DATA_W  (DATA_W),
        .TMR_BIT (TMR_BIT)
    ) u_sys (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_vld_i (set_vld_i),
        .set_idx_i (set_idx_i),
        .clr_vld_i (clr_vld_i),
        .clr_idx_i (clr_idx_i),
        .tmr_clr_i (strb.tmr_clr),
        .mask_we_i (strb.sys_mask_we),
        .wdata_i   (bus_wdata_i),
        .pend_o    (sys_pend_q),
        .mask_o    (sys_mask_q),
        .irq_o     (sys_irq_o)
    );

    sys_irq_grp_w1c #(
        .DATA_W (DATA_W)
    ) u_cm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_i     (cm_src_i),
        .w1c_i     (strb.cm_w1c),
        .mask_we_i (strb.cm_mask_we),
        .cfg_we_i  (strb.cm_cfg_we),
        .wdata_i   (bus_wdata_i),
        .pend_o    (cm_pend_q),
        .mask_o    (cm_mask_q),
        .cfg_o     (cm_cfg_q),
        .irq_o     (cm_irq_o)
    );

endmodule

// File: rtl/sys_irq_ctrl_chk.sv
module sys_irq_ctrl_chk
    import sys_irq_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned TMR_BIT     = 30,
    parameter int unsigned TMR_ACK_BIT = 7,
    localparam int unsigned IDX_W      = $clog2(DATA_W)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              set_vld_i,
    input logic [IDX_W-1:0]  set_idx_i,
    input logic              clr_vld_i,
    input logic [IDX_W-1:0]  clr_idx_i,
    input logic [DATA_W-1:0] cm_src_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              sys_irq_o,
    input logic              cm_irq_o,
    input logic [DATA_W-1:0] sys_pend,
    input logic [DATA_W-1:0] sys_mask,
    input logic [DATA_W-1:0] cm_pend,
    input logic [DATA_W-1:0] cm_mask
);

    logic wr_sys_pend, wr_tmr, wr_cm_pend;
    assign wr_sys_pend = bus_we_i && (bus_addr_i == ADDR_W'(REG_SYS_PEND));
    assign wr_tmr      = bus_we_i && (bus_addr_i == ADDR_W'(REG_TMR_STAT));
    assign wr_cm_pend  = bus_we_i && (bus_addr_i == ADDR_W'(REG_CM_PEND));

    // R2
    idx_set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_vld_i |=> sys_pend[$past(set_idx_i)]);

    // R3
    idx_clr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_vld_i && !(set_vld_i && (set_idx_i == clr_idx_i)))
        |=> !sys_pend[$past(clr_idx_i)]);

    // R5
    pend_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_sys_pend && !set_vld_i && !clr_vld_i) |=> $stable(sys_pend));

    // R6
    sys_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_irq_o |-> ((sys_pend != '0) && (sys_mask != '0)));

    // R7
    tmr_ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_tmr && bus_wdata_i[TMR_ACK_BIT]
         && !(set_vld_i && (set_idx_i == IDX_W'(TMR_BIT))))
        |=> !sys_pend[TMR_BIT]);

    // R8
    w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_cm_pend |=> ((cm_pend & $past(bus_wdata_i & ~cm_src_i)) == '0));

    // R9
    src_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cm_src_i != '0) |=> ((cm_pend & $past(cm_src_i)) == $past(cm_src_i)));

    // R10
    cm_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cm_irq_o |-> ((cm_pend != '0) && (cm_mask != '0)));

endmodule

bind sys_irq_ctrl sys_irq_ctrl_chk #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .TMR_BIT     (TMR_BIT),
    .TMR_ACK_BIT (TMR_ACK_BIT)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_vld_i   (set_vld_i),
    .set_idx_i   (set_idx_i),
    .clr_vld_i   (clr_vld_i),
    .clr_idx_i   (clr_idx_i),
    .cm_src_i    (cm_src_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .sys_irq_o   (sys_irq_o),
    .cm_irq_o    (cm_irq_o),
    .sys_pend    (sys_pend_q),
    .sys_mask    (sys_mask_q),
    .cm_pend     (cm_pend_q),
    .cm_mask     (cm_mask_q)
);

// File: tb/sys_irq_ctrl_test.sv
`timescale 1ns/1ps
module sys_irq_ctrl_test;

    localparam int DW = 32;
    localparam int AW = 4;
    localparam logic [AW-1:0] A_SPEND = 4'd0, A_SMASK = 4'd1, A_TMR = 4'd2,
                              A_CPEND = 4'd3, A_CMASK = 4'd4, A_CCFG = 4'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          set_vld = 1'b0, clr_vld = 1'b0;
    logic [4:0]    set_idx = '0, clr_idx = '0;
    logic [DW-1:0] cm_src = '0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          sys_irq, cm_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] sys_exp = '0, cm_exp = '0;

    always #5 clk = ~clk;

    sys_irq_ctrl uut (
        .clk_i (clk), .rst_ni (rst_n),
        .set_vld_i (set_vld), .set_idx_i (set_idx),
        .clr_vld_i (clr_vld), .clr_idx_i (clr_idx),
        .cm_src_i (cm_src),
        .bus_we_i (we), .bus_addr_i (addr), .bus_wdata_i (wdata),
        .bus_rdata_o (rdata), .sys_irq_o (sys_irq), .cm_irq_o (cm_irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic idx_op(input logic sv, input logic [4:0] si, input logic cv, input logic [4:0] ci);
        @(negedge clk);
        set_vld = sv; set_idx = si; clr_vld = cv; clr_idx = ci;
        @(negedge clk);
        set_vld = 1'b0; clr_vld = 1'b0;
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(AW'(a), v);
            check("R1 reset reg", v, '0);
        end
        check("R1 sys_irq", DW'(sys_irq), '0);
        check("R1 cm_irq", DW'(cm_irq), '0);
    endtask

    task automatic t_set_clear;
        logic [DW-1:0] v;
        idx_op(1'b1, 5'd3, 1'b0, 5'd0);
        idx_op(1'b1, 5'd31, 1'b0, 5'd0);
        idx_op(1'b1, 5'd0, 1'b0, 5'd0);
        sys_exp = 32'h8000_0009;
        rd(A_SPEND, v);
        check("R2 indexed set", v, sys_exp);
        idx_op(1'b0, 5'd0, 1'b1, 5'd3);
        sys_exp = 32'h8000_0001;
        rd(A_SPEND, v);
        check("R3 indexed clear", v, sys_exp);
    endtask

    task automatic t_set_wins;
        logic [DW-1:0] v;
        idx_op(1'b1, 5'd5, 1'b1, 5'd5);
        sys_exp |= 32'h20;
        rd(A_SPEND, v);
        check("R4 set beats clear", v, sys_exp);
        idx_op(1'b1, 5'd6, 1'b1, 5'd5);
        sys_exp = (sys_exp | 32'h40) & ~32'h20;
        rd(A_SPEND, v);
        check("R4 distinct set and clear", v, sys_exp);
    endtask

    task automatic t_pend_ro;
        logic [DW-1:0] v;
        wr(A_SPEND, 32'hFFFF_FFFF);
        rd(A_SPEND, v);
        check("R5 pend ones write ignored", v, sys_exp);
        wr(A_SPEND, 32'h0);
        rd(A_SPEND, v);
        check("R5 pend zero write ignored", v, sys_exp);
    endtask

    task automatic t_sys_mask;
        logic [DW-1:0] v;
        wr(A_SMASK, 32'h0000_0002);
        rd(A_SMASK, v);
        check("R6 mask readback", v, 32'h2);
        check("R6 irq low no overlap", DW'(sys_irq), '0);
        wr(A_SMASK, 32'h0000_0001);
        check("R6 irq high on overlap", DW'(sys_irq), 32'h1);
        wr(A_SMASK, 32'h0);
        check("R6 irq low mask cleared", DW'(sys_irq), '0);
    endtask

    task automatic t_timer;
        logic [DW-1:0] v;
        idx_op(1'b1, 5'd30, 1'b0, 5'd0);
        idx_op(1'b1, 5'd29, 1'b0, 5'd0);
        sys_exp |= 32'h6000_0000;
        wr(A_TMR, 32'hFFFF_FF7F);
        rd(A_SPEND, v);
        check("R7 no ack bit no effect", v, sys_exp);
        wr(A_TMR, 32'h0000_0080);
        sys_exp &= ~32'h4000_0000;
        rd(A_SPEND, v);
        check("R7 ack clears bit 30 only", v, sys_exp);
        rd(A_TMR, v);
        check("R12 timer reads zero", v, '0);
        @(negedge clk);
        we = 1'b1; addr = A_TMR; wdata = 32'h80; set_vld = 1'b1; set_idx = 5'd30;
        @(negedge clk);
        we = 1'b0; wdata = '0; set_vld = 1'b0;
        sys_exp |= 32'h4000_0000;
        rd(A_SPEND, v);
        check("R7 set of bit 30 beats ack", v, sys_exp);
    endtask

    task automatic t_cm_w1c;
        logic [DW-1:0] v;
        @(negedge clk);
        cm_src = 32'h0000_F0F0;
        @(negedge clk);
        cm_src = '0;
        cm_exp = 32'h0000_F0F0;
        rd(A_CPEND, v);
        check("R9 source set", v, cm_exp);
        wr(A_CPEND, 32'h0000_00F0);
        cm_exp = 32'h0000_F000;
        rd(A_CPEND, v);
        check("R8 w1c clears ones keeps zeros", v, cm_exp);
    endtask

    task automatic t_cm_set_wins;
        logic [DW-1:0] v;
        @(negedge clk);
        we = 1'b1; addr = A_CPEND; wdata = 32'h0000_9000; cm_src = 32'h0000_1000;
        @(negedge clk);
        we = 1'b0; wdata = '0; cm_src = '0;
        cm_exp = 32'h0000_7000;
        rd(A_CPEND, v);
        check("R9 source beats w1c", v, cm_exp);
    endtask

    task automatic t_cm_mask;
        logic [DW-1:0] v;
        wr(A_CMASK, 32'h0000_0001);
        rd(A_CMASK, v);
        check("R10 cm mask readback", v, 32'h1);
        check("R10 cm irq low no overlap", DW'(cm_irq), '0);
        wr(A_CMASK, 32'h0000_1000);
        check("R10 cm irq high on overlap", DW'(cm_irq), 32'h1);
        check("R10 sys irq independent", DW'(sys_irq), '0);
        wr(A_CPEND, 32'h0000_1000);
        check("R10 cm irq low after w1c", DW'(cm_irq), '0);
        cm_exp &= ~32'h1000;
    endtask

    task automatic t_cfg;
        logic [DW-1:0] v;
        wr(A_CCFG, 32'hA5A5_5A5A);
        rd(A_CCFG, v);
        check("R11 cfg readback", v, 32'hA5A5_5A5A);
        check("R11 cm irq unaffected", DW'(cm_irq), '0);
        check("R11 sys irq unaffected", DW'(sys_irq), '0);
        rd(A_CPEND, v);
        check("R11 cm pend unaffected", v, cm_exp);
    endtask

    task automatic t_unmapped;
        logic [DW-1:0] v;
        rd(4'd6, v);
        check("R12 addr 6 reads zero", v, '0);
        rd(4'd9, v);
        check("R12 addr 9 reads zero", v, '0);
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd12, 32'hFFFF_FFFF);
        rd(A_SMASK, v);
        check("R12 sys mask untouched", v, '0);
        rd(A_CMASK, v);
        check("R12 cm mask untouched", v, 32'h1000);
        rd(A_CPEND, v);
        check("R12 cm pend untouched", v, cm_exp);
        rd(A_SPEND, v);
        check("R12 sys pend untouched", v, sys_exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_set_wins();
        t_pend_ro();
        t_sys_mask();
        t_timer();
        t_cm_w1c();
        t_cm_set_wins();
        t_cm_mask();
        t_cfg();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule